// File: doc/BRIEF.md
# Masked Parallel Priority Interrupt Controller

This block collects four interrupt request lines from peripherals into a pending register that holds each request until software clears it. A mask register, which software sets and clears bit by bit, qualifies the pending bits. A fixed priority encoder then picks the most urgent qualified source. Line 0 is the most urgent and line 3 the least.

One interrupt line goes to the processor. It is high only while a global enable flag is set and at least one qualified source is pending. When the processor acknowledges, the block returns a vector address. The vector is the two-bit index of the winning source, zero-extended to the bus width. Every acknowledge also clears the global enable, so that no second interrupt nests until software turns it back on. Outside an acknowledge, the vector output is forced to zero with its valid flag low. This models a bus buffer in its high-impedance state.

Top module: `pic_parallel_prio`

## Requirements
- R1: After a synchronous reset, the pending register, the mask register and the global enable are all zero. As a result, `cpu_int`, `vec_valid` and `vec_addr` are all zero even while `int_ack` is high.
- R2: A high level on `irq_req[i]` at a clock edge sets pending bit i. The bit stays set after the request line falls.
- R3: A high `pend_clr[i]` at a clock edge clears pending bit i, and only that bit. If `irq_req[i]` is high in the same cycle, the bit stays set.
- R4: `mask_set[i]` sets mask bit i and `mask_clr[i]` clears it; when both are high, the bit ends up set. A pending source whose mask bit is zero has no effect on `cpu_int`, `vec_valid` or `vec_addr`.
- R5: Among the pending and unmasked sources, the one with the lowest index wins. The index, as an unsigned binary number, appears in `vec_addr[1:0]`, and all higher bits of `vec_addr` are zero (source 3 gives 8'b00000011).
- R6: `cpu_int` is high exactly when the global enable is set and at least one source is pending and unmasked. `ien_on` sets the enable at the next edge and `ien_off` clears it. When both are high, `ien_off` wins.
- R7: `vec_valid` is high exactly when `int_ack` is high and at least one source is pending and unmasked. While `vec_valid` is low, `vec_addr` is zero.
- R8: A high `int_ack` at a clock edge clears the global enable. This overrides `ien_on` in the same cycle.
- R9: An acknowledge leaves the pending bits unchanged. The same vector is presented again on the next acknowledge unless software has cleared the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_SRC | Request lines from the peripherals |
| pend_clr | input | N_SRC | Per-bit clear of the pending register |
| mask_set | input | N_SRC | Per-bit set of the mask register |
| mask_clr | input | N_SRC | Per-bit clear of the mask register |
| ien_on | input | 1 | Set the global interrupt enable |
| ien_off | input | 1 | Clear the global interrupt enable |
| int_ack | input | 1 | Acknowledge from the processor |
| cpu_int | output | 1 | Interrupt line to the processor |
| vec_valid | output | 1 | Vector is being driven |
| vec_addr | output | VEC_W | Vector address, zero when not driven |

## Verification
The assertions make two assumptions about how the processor uses the block. First, an acknowledge is a request to read the vector and is never held across the enable being turned back on. This is why an acknowledge is assumed to silence the interrupt line on the next cycle. Second, the enable commands arrive only as the listed pulses. The stimulus follows both assumptions, because every cycle is driven from one task whose arguments set all command pulses together. Directed steps exercise same-cycle conflicts: a request against a clear, a mask set against a mask clear, enable on against enable off, and acknowledge against enable on. A seeded pseudo-random phase then draws sparse pulses for the same inputs.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int unsigned PIC_N_SRC = 4;
    localparam int unsigned PIC_VEC_W = 8;

    typedef enum logic [1:0] {
        EN_HOLD = 2'd0,
        EN_SET  = 2'd1,
        EN_DROP = 2'd2
    } en_cmd_e;

    // Resolve the enable command: acknowledge and disable both drop.
    function automatic en_cmd_e en_resolve(input logic on, input logic off, input logic ack);
        en_cmd_e c;
        if (ack || off) c = EN_DROP;
        else if (on)    c = EN_SET;
        else            c = EN_HOLD;
        return c;
    endfunction

    // Set-dominant per-bit register update.
    function automatic logic [PIC_N_SRC-1:0] bit_update(input logic [PIC_N_SRC-1:0] cur,
                                                        input logic [PIC_N_SRC-1:0] setv,
                                                        input logic [PIC_N_SRC-1:0] clrv);
        return (cur & ~clrv) | setv;
    endfunction

endpackage

// File: rtl/pic_pend_reg.sv
module pic_pend_reg #(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | req;
    end
endmodule

// File: rtl/pic_mask_reg.sv
module pic_mask_reg #(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] mset,
    input  logic [N_SRC-1:0] mclr,
    output logic [N_SRC-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst) mask <= '0;
        else     mask <= (mask & ~mclr) | mset;
    end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int unsigned N_SRC  = 4,
    parameter int unsigned CODE_W = 2
) (
    input  logic [N_SRC-1:0]  qual,
    output logic [CODE_W-1:0] code,
    output logic              any
);
    assign any = |qual;

    generate
        if (N_SRC == 4 && CODE_W == 2) begin : g_four
            // Two-level sum of products for four inputs.
            logic hi, lo;
            assign hi   = ~qual[0] & ~qual[1];
            assign lo   = (~qual[0] & qual[1]) | (~qual[0] & ~qual[2]);
            assign code = {hi, lo};
        end else begin : g_generic
            always_comb begin
                code = '0;
                for (int i = N_SRC - 1; i >= 0; i--) begin
                    if (qual[i]) code = CODE_W'(i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pic_en_ctrl.sv
module pic_en_ctrl
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic on,
    input  logic off,
    input  logic ack,
    output logic en
);
    en_cmd_e cmd;

    always_comb cmd = en_resolve(on, off, ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= 1'b0;
        end else begin
            unique case (cmd)
                EN_SET:  en <= 1'b1;
                EN_DROP: en <= 1'b0;
                default: en <= en;
            endcase
        end
    end
endmodule

// File: rtl/pic_parallel_prio.sv
module pic_parallel_prio
    import pic_pkg::*;
#(
    parameter int unsigned N_SRC = PIC_N_SRC,
    parameter int unsigned VEC_W = PIC_VEC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC-1:0] pend_clr,
    input  logic [N_SRC-1:0] mask_set,
    input  logic [N_SRC-1:0] mask_clr,
    input  logic             ien_on,
    input  logic             ien_off,
    input  logic             int_ack,
    output logic             cpu_int,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_addr
);
    localparam int unsigned CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  mask;
    logic [N_SRC-1:0]  qual;
    logic [CODE_W-1:0] code;
    logic              ist;
    logic              ien;

    pic_pend_reg #(.N_SRC(N_SRC)) u_pend (
        .clk (clk), .rst (rst), .req (irq_req), .clr (pend_clr), .pend (pend)
    );

    pic_mask_reg #(.N_SRC(N_SRC)) u_mask (
        .clk (clk), .rst (rst), .mset (mask_set), .mclr (mask_clr), .mask (mask)
    );

    assign qual = pend & mask;

    pic_prio_enc #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_enc (
        .qual (qual), .code (code), .any (ist)
    );

    pic_en_ctrl u_en (
        .clk (clk), .rst (rst), .on (ien_on), .off (ien_off), .ack (int_ack), .en (ien)
    );

    assign cpu_int   = ien & ist;
    assign vec_valid = int_ack & ist;
    assign vec_addr  = vec_valid ? VEC_W'(code) : '0;
endmodule

// File: rtl/pic_parallel_prio_chk.sv
module pic_parallel_prio_chk #(
    parameter int unsigned N_SRC = 4,
    parameter int unsigned VEC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ien_off,
    input logic             int_ack,
    input logic             cpu_int,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_addr
);
    localparam int unsigned CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    AST_ACK_DROPS_INT: assert property (@(posedge clk) disable iff (rst)
        int_ack |=> !cpu_int);                                   // R8
    AST_OFF_DROPS_INT: assert property (@(posedge clk) disable iff (rst)
        ien_off |=> !cpu_int);                                   // R6
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> (vec_addr == '0));                        // R7
    AST_VEC_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> ((vec_addr >> CODE_W) == '0));             // R5
    AST_NO_SRC_NO_INT: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !vec_valid) |-> !cpu_int);                   // R6
    AST_VALID_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> int_ack);                                  // R7
endmodule

bind pic_parallel_prio pic_parallel_prio_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
    .clk (clk), .rst (rst), .ien_off (ien_off), .int_ack (int_ack),
    .cpu_int (cpu_int), .vec_valid (vec_valid), .vec_addr (vec_addr)
);

// File: tb/sim_pic_parallel_prio.sv
module sim_pic_parallel_prio;
    localparam int N = 4;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] irq_req, pend_clr, mask_set, mask_clr;
    logic         ien_on, ien_off, int_ack;
    logic         cpu_int, vec_valid;
    logic [W-1:0] vec_addr;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural reference state
    bit [N-1:0] m_pend, m_mask;
    bit         m_en;

    always #2 clk = ~clk;

    pic_parallel_prio #(.N_SRC(N), .VEC_W(W)) u0 (
        .clk (clk), .rst (rst), .irq_req (irq_req), .pend_clr (pend_clr),
        .mask_set (mask_set), .mask_clr (mask_clr), .ien_on (ien_on),
        .ien_off (ien_off), .int_ack (int_ack), .cpu_int (cpu_int),
        .vec_valid (vec_valid), .vec_addr (vec_addr)
    );

    task automatic step(input bit [N-1:0] rq, input bit [N-1:0] cl,
                        input bit [N-1:0] ms, input bit [N-1:0] mc,
                        input bit on, input bit off, input bit ack, input string tag);
        int winner;
        bit e_int, e_val;
        int e_vec;
        irq_req = rq; pend_clr = cl; mask_set = ms; mask_clr = mc;
        ien_on = on; ien_off = off; int_ack = ack;
        #1;
        winner = -1;
        for (int i = 0; i < N; i++)
            if (winner < 0 && m_pend[i] && m_mask[i]) winner = i;
        e_int = m_en && (winner >= 0);
        e_val = ack && (winner >= 0);
        e_vec = e_val ? winner : 0;
        n_tests++;
        if (cpu_int !== e_int || vec_valid !== e_val || int'(vec_addr) != e_vec) begin
            n_fail++;
            $display("FAIL %s: int/valid/vec got %0b/%0b/%0d expected %0b/%0b/%0d",
                     tag, cpu_int, vec_valid, vec_addr, e_int, e_val, e_vec);
        end
        @(posedge clk);
        if (rst) begin
            m_pend = '0; m_mask = '0; m_en = 1'b0;
        end else begin
            m_pend = (m_pend & ~cl) | rq;
            m_mask = (m_mask & ~mc) | ms;
            if (ack || off) m_en = 1'b0;
            else if (on)    m_en = 1'b1;
        end
        @(negedge clk);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lfsr;
        m_pend = '0; m_mask = '0; m_en = 1'b0;
        rst = 1'b1;
        irq_req = '0; pend_clr = '0; mask_set = '0; mask_clr = '0;
        ien_on = 0; ien_off = 0; int_ack = 0;
        @(negedge clk);
        step(4'hF, 0, 4'hF, 0, 1, 0, 0, "R1");
        step(4'hF, 0, 4'hF, 0, 1, 0, 0, "R1");
        rst = 1'b0;
        // R1: reset state, ack shows nothing
        step(0, 0, 0, 0, 0, 0, 1, "R1");
        // R2 / R4: request held, masked out
        step(4'b1000, 0, 0, 0, 1, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 1, "R4");
        step(0, 0, 0, 0, 1, 0, 0, "R4");
        step(0, 0, 4'b1000, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 1, "R9");
        // R5: priority ordering
        step(4'b0110, 0, 4'hF, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, 1, "R5");
        step(4'b0001, 0, 0, 0, 0, 0, 1, "R5");
        step(0, 4'b0001, 0, 0, 0, 0, 1, "R5");
        step(0, 4'b0010, 0, 0, 0, 0, 1, "R3");
        // R3: clear vs simultaneous request
        step(4'b0100, 4'b0100, 0, 0, 0, 0, 1, "R3");
        step(0, 0, 0, 0, 0, 0, 1, "R3");
        // R4: mask clear, mask set/clear conflict
        step(0, 0, 0, 4'b0100, 0, 0, 1, "R4");
        step(0, 0, 4'b0100, 4'b0100, 0, 0, 1, "R4");
        step(0, 0, 0, 0, 0, 0, 1, "R4");
        // R6: on/off conflict; R8: ack vs on
        step(0, 0, 0, 0, 1, 1, 0, "R6");
        step(0, 0, 0, 0, 1, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 1, 0, 1, "R8");
        step(0, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 4'hF, 0, 0, 1, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, 1, "R7");
        // pseudo-random phase
        lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 400; k++) begin
            bit [N-1:0] rq, cl, ms, mc;
            lfsr = (lfsr << 1) ^ ((lfsr < 0) ? 32'h04C1_1DB7 : 0);
            rq = 4'(lfsr) & 4'(lfsr >> 4) & 4'(lfsr >> 8);
            cl = 4'(lfsr >> 12) & 4'(lfsr >> 16);
            ms = 4'(lfsr >> 20) & 4'(lfsr >> 24);
            mc = 4'(lfsr >> 5) & 4'(lfsr >> 9) & 4'(lfsr >> 13);
            step(rq, cl, ms, mc, lfsr[28] & lfsr[3], lfsr[29] & lfsr[30] & lfsr[2],
                 lfsr[31] & lfsr[27], "R5");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule